// File: doc/BRIEF.md
# Signalling Block Parity Encoder

This block takes a signalling message of 184 bits, one bit per accepted beat, and produces a 228-bit coded frame for a rate-1/2 convolutional coder further down the chain. The frame is built in three parts: the message bits unchanged, then 40 parity bits from a shortened cyclic burst-correcting code, then four zero tail bits. The zero tail bits drive the following convolutional coder back to its all-zero state.

The input side is a valid/ready bit stream that carries start and end markers. A message is stored while a 40-stage divider builds the remainder. The coded frame is released only after the end marker arrives on the 184th bit. A message of the wrong length is discarded and reported by a one-cycle error pulse, and nothing is emitted for it. The output side is a valid/ready bit stream that carries start and end markers. Holding the output ready low freezes the frame in place.

Top module: `fire_encoder`

## Requirements
- R1: Every emitted frame is exactly 228 handshaken bits long. `out_sof` is high on the first bit only and `out_eof` is high on the last bit only.
- R2: Frame bits 0..183 equal the message bits in the order they were accepted.
- R3: Frame bits 184..223 are the inverted remainder of m(D)·D^40 divided by g(D) = D^40+D^26+D^23+D^17+D^3+1, which is (D^23+1)(D^17+D^3+1). The first message bit is the highest-degree coefficient of m(D), and the remainder is emitted starting from its D^39 coefficient.
- R4: Frame bits 224..227 are zero.
- R5: `in_ready` is low while a frame is being emitted and high at all other times.
- R6: While `out_valid` is high and `out_ready` is low, the output bit and markers hold, and no frame bit is skipped or repeated.
- R7: A message whose end marker comes on any bit before the 184th raises `len_err` for one cycle, on the cycle after that bit is accepted. No frame is emitted for it.
- R8: A message that reaches a 185th bit without an end marker raises `len_err` on the cycle after that bit is accepted. No frame is emitted for it, and further bits are ignored until the next start marker.
- R9: Bits accepted while no message is open and without a start marker are ignored. They raise no error and emit nothing.
- R10: A start marker that arrives while a message is open drops the open message with a `len_err` pulse and starts a new message with that bit.
- R11: After reset, `out_valid` and `len_err` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input bit is offered |
| in_ready | output | 1 | Encoder can accept an input bit |
| in_data | input | 1 | Message bit |
| in_sof | input | 1 | First bit of a message |
| in_eof | input | 1 | Last bit of a message |
| out_valid | output | 1 | Output bit is offered |
| out_ready | input | 1 | Downstream accepts the output bit |
| out_data | output | 1 | Coded frame bit |
| out_sof | output | 1 | First bit of the coded frame |
| out_eof | output | 1 | Last bit of the coded frame |
| len_err | output | 1 | One-cycle pulse when a message is dropped |

## Verification
A fault in the divider does not show on any port until the parity section of the next frame. It then appears as a wrong bit among frame positions 184..223, at least 184 output beats after the fault. A wrong length count shows up sooner and more plainly. Either a valid message gets a spurious `len_err` pulse one cycle after its last bit, or a bad message emits a frame, or `out_sof`/`out_eof` fall at the wrong positions. A corrupted output counter moves the parity and tail sections, which the per-position frame comparison detects.

// File: rtl/fire_pkg.sv
package fire_pkg;
    localparam int MSG_BITS   = 184;
    localparam int PAR_BITS   = 40;
    localparam int TAIL_BITS  = 4;
    localparam int FRAME_BITS = MSG_BITS + PAR_BITS + TAIL_BITS;

    // g(D) = D^40 + D^26 + D^23 + D^17 + D^3 + 1, leading term implied
    localparam logic [PAR_BITS-1:0] GEN_TAPS = 40'h00_0482_0009;

    typedef enum logic {
        ST_LOAD,
        ST_SEND
    } enc_state_e;

    typedef enum logic [1:0] {
        SEG_MSG,
        SEG_PAR,
        SEG_TAIL
    } out_seg_e;
endpackage

// File: rtl/fire_lfsr.sv
module fire_lfsr #(
    parameter int              W    = fire_pkg::PAR_BITS,
    parameter logic [W-1:0]    TAPS = fire_pkg::GEN_TAPS
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    input  logic shift,
    input  logic din,
    output logic msb
);
    logic [W-1:0] rem_q;
    logic [W-1:0] base;
    logic         fb;
    logic [W-1:0] nxt;

    always_comb begin
        base = clr ? '0 : rem_q;
        fb   = din ^ base[W-1];
        nxt  = {base[W-2:0], 1'b0} ^ (fb ? TAPS : '0);
    end

    always_ff @(posedge clk) begin
        if (rst)        rem_q <= '0;
        else if (step)  rem_q <= nxt;
        else if (shift) rem_q <= {rem_q[W-2:0], 1'b0};
    end

    assign msb = rem_q[W-1];
endmodule

// File: rtl/msg_buffer.sv
module msg_buffer #(
    parameter int W = fire_pkg::MSG_BITS
) (
    input  logic clk,
    input  logic rst,
    input  logic shift,
    input  logic din,
    output logic msb
);
    logic [W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst)        sr_q <= '0;
        else if (shift) sr_q <= {sr_q[W-2:0], din};
    end

    assign msb = sr_q[W-1];
endmodule

// File: rtl/frame_tracker.sv
module frame_tracker #(
    parameter int MSG_BITS = fire_pkg::MSG_BITS
) (
    input  logic clk,
    input  logic rst,
    input  logic acc,
    input  logic sof,
    input  logic eof,
    output logic start,
    output logic take,
    output logic done,
    output logic err
);
    localparam int CW = $clog2(MSG_BITS + 1);
    localparam logic [CW-1:0] LAST_IDX = CW'(MSG_BITS - 1);
    localparam logic [CW-1:0] FULL_IDX = CW'(MSG_BITS);

    logic          open_q;
    logic [CW-1:0] idx_q;
    logic [CW-1:0] cur_idx;
    logic          overrun;
    logic          restart;
    logic          bad_eof;

    always_comb begin
        cur_idx = sof ? '0 : idx_q;
        overrun = acc && open_q && !sof && (idx_q == FULL_IDX);
        restart = acc && sof && open_q;
        start   = acc && sof;
        take    = acc && (sof || open_q) && !overrun;
        done    = take && eof && (cur_idx == LAST_IDX);
        bad_eof = take && eof && (cur_idx != LAST_IDX);
        err     = bad_eof || overrun || restart;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            idx_q  <= '0;
        end else if (acc) begin
            if (sof) begin
                open_q <= !eof;
                idx_q  <= CW'(1);
            end else if (open_q) begin
                if (eof || overrun) open_q <= 1'b0;
                else                idx_q  <= idx_q + CW'(1);
            end
        end
    end
endmodule

// File: rtl/fire_encoder.sv
module fire_encoder
    import fire_pkg::*;
#(
    parameter int                    P_MSG  = fire_pkg::MSG_BITS,
    parameter int                    P_PAR  = fire_pkg::PAR_BITS,
    parameter int                    P_TAIL = fire_pkg::TAIL_BITS,
    parameter logic [P_PAR-1:0]      P_TAPS = fire_pkg::GEN_TAPS
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic in_ready,
    input  logic in_data,
    input  logic in_sof,
    input  logic in_eof,
    output logic out_valid,
    input  logic out_ready,
    output logic out_data,
    output logic out_sof,
    output logic out_eof,
    output logic len_err
);
    localparam int FRAME = P_MSG + P_PAR + P_TAIL;
    localparam int FCW   = $clog2(FRAME);
    localparam logic [FCW-1:0] PAR_START = FCW'(P_MSG);
    localparam logic [FCW-1:0] TAIL_START = FCW'(P_MSG + P_PAR);
    localparam logic [FCW-1:0] LAST_POS  = FCW'(FRAME - 1);

    enc_state_e     state_q;
    logic [FCW-1:0] pos_q;
    out_seg_e       seg;
    logic           acc, hs;
    logic           start, take, done, err;
    logic           buf_msb, par_msb;

    assign in_ready  = (state_q == ST_LOAD);
    assign out_valid = (state_q == ST_SEND);
    assign acc       = in_valid && in_ready;
    assign hs        = out_valid && out_ready;

    always_comb begin
        if (pos_q < PAR_START)       seg = SEG_MSG;
        else if (pos_q < TAIL_START) seg = SEG_PAR;
        else                         seg = SEG_TAIL;
    end

    frame_tracker #(.MSG_BITS(P_MSG)) u_track (
        .clk(clk), .rst(rst), .acc(acc), .sof(in_sof), .eof(in_eof),
        .start(start), .take(take), .done(done), .err(err)
    );

    msg_buffer #(.W(P_MSG)) u_buf (
        .clk(clk), .rst(rst),
        .shift(take || (hs && seg == SEG_MSG)),
        .din(take ? in_data : 1'b0),
        .msb(buf_msb)
    );

    fire_lfsr #(.W(P_PAR), .TAPS(P_TAPS)) u_div (
        .clk(clk), .rst(rst),
        .clr(start), .step(take),
        .shift(hs && seg == SEG_PAR),
        .din(in_data),
        .msb(par_msb)
    );

    always_comb begin
        unique case (seg)
            SEG_MSG: out_data = buf_msb;
            SEG_PAR: out_data = ~par_msb;
            default: out_data = 1'b0;
        endcase
    end

    assign out_sof = out_valid && (pos_q == '0);
    assign out_eof = out_valid && (pos_q == LAST_POS);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LOAD;
            pos_q   <= '0;
            len_err <= 1'b0;
        end else begin
            len_err <= err;
            if (state_q == ST_LOAD) begin
                pos_q <= '0;
                if (done) state_q <= ST_SEND;
            end else if (hs) begin
                if (pos_q == LAST_POS) begin
                    state_q <= ST_LOAD;
                    pos_q   <= '0;
                end else begin
                    pos_q <= pos_q + FCW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/fire_encoder_chk.sv
module fire_encoder_chk #(
    parameter int P_MSG   = fire_pkg::MSG_BITS,
    parameter int P_PAR   = fire_pkg::PAR_BITS,
    parameter int P_FRAME = fire_pkg::FRAME_BITS
) (
    input logic clk,
    input logic rst,
    input logic in_ready,
    input logic out_valid,
    input logic out_ready,
    input logic out_data,
    input logic out_sof,
    input logic out_eof,
    input logic len_err
);
    int unsigned beat_q;

    always_ff @(posedge clk) begin
        if (rst) beat_q <= 0;
        else if (out_valid && out_ready) beat_q <= out_eof ? 0 : beat_q + 1;
    end

    AST_READY_LOW_IN_SEND: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready); // R5
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
            && $stable(out_sof) && $stable(out_eof))); // R6
    AST_SOF_FIRST: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sof) |-> (beat_q == 0)); // R1
    AST_EOF_LAST: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_eof) |-> (beat_q == P_FRAME - 1)); // R1
    AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && beat_q >= P_MSG + P_PAR) |-> !out_data); // R4
    AST_DROP_SILENT: assert property (@(posedge clk) disable iff (rst)
        len_err |-> !out_valid); // R7
endmodule

bind fire_encoder fire_encoder_chk u_chk (
    .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof),
    .out_eof(out_eof), .len_err(len_err)
);

// File: tb/fire_encoder_bench.sv
module fire_encoder_bench;
    localparam int NM = 184;
    localparam int NP = 40;
    localparam int NF = 228;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, in_data = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic out_ready = 1'b1;
    logic in_ready, out_valid, out_data, out_sof, out_eof, len_err;

    int tests = 0;
    int fails = 0;
    logic last_err;
    logic [31:0] lcg = 32'h1234_5678;

    always #10 clk = ~clk;

    fire_encoder u_fire_encoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sof(out_sof), .out_eof(out_eof), .len_err(len_err)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic b, input logic s, input logic e);
        @(negedge clk);
        in_valid = 1'b1; in_data = b; in_sof = s; in_eof = e;
        @(posedge clk);
        #1;
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        last_err = len_err;
    endtask

    function automatic logic [0:NP-1] ref_parity(input logic [0:NM-1] m);
        logic [0:NM+NP-1] a;
        int offs [6] = '{0, 14, 17, 23, 37, 40};
        logic [0:NP-1] p;
        a = '0;
        for (int i = 0; i < NM; i++) a[i] = m[i];
        for (int i = 0; i < NM; i++)
            if (a[i]) for (int k = 0; k < 6; k++) a[i + offs[k]] = ~a[i + offs[k]];
        for (int j = 0; j < NP; j++) p[j] = ~a[NM + j];
        return p;
    endfunction

    task automatic expect_idle(input int cycles, input string req);
        int seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (out_valid) seen++;
        end
        check(seen == 0, req, seen, 0);
    endtask

    // Collects one frame and checks R1..R6 against the reference.
    task automatic collect_check(input logic [0:NM-1] m, input int stall, input string tag);
        logic [0:NF-1] got, gs, ge;
        logic [0:NP-1] p;
        int n = 0, guard = 0, bad_rdy = 0, e_msg = 0, e_par = 0, e_tail = 0;
        while (n < NF && guard < 4000) begin
            @(negedge clk);
            out_ready = (stall == 0) ? 1'b1 : ((guard % 3) != 0);
            #2;
            if (out_valid && in_ready) bad_rdy++;
            if (out_valid && out_ready) begin
                got[n] = out_data; gs[n] = out_sof; ge[n] = out_eof; n++;
            end
            guard++;
        end
        out_ready = 1'b1;
        check(n == NF, {tag, " R1 frame length"}, n, NF);
        check(gs[0] && !(|gs[1:NF-1]) && ge[NF-1] && !(|ge[0:NF-2]),
              {tag, " R1 markers"}, {gs[0], ge[NF-1]}, 2'b11);
        for (int i = 0; i < NM; i++) if (got[i] !== m[i]) e_msg++;
        check(e_msg == 0, {tag, " R2 message bits"}, e_msg, 0);
        p = ref_parity(m);
        for (int j = 0; j < NP; j++) if (got[NM + j] !== p[j]) e_par++;
        check(e_par == 0, {tag, " R3 parity"}, got[NM +: NP], p);
        for (int t = NM + NP; t < NF; t++) if (got[t] !== 1'b0) e_tail++;
        check(e_tail == 0, {tag, " R4 tail"}, e_tail, 0);
        check(bad_rdy == 0, {tag, " R5 ready low while sending"}, bad_rdy, 0);
        if (stall != 0) check(n == NF && e_msg == 0 && e_par == 0, {tag, " R6 stalled output"}, e_msg + e_par, 0);
        @(negedge clk);
        check(in_ready && !out_valid, {tag, " R5 ready back after frame"}, {in_ready, out_valid}, 2'b10);
    endtask

    task automatic send_msg(input logic [0:NM-1] m, output logic first_err, output logic end_err);
        for (int i = 0; i < NM; i++) begin
            push(m[i], i == 0, i == NM - 1);
            if (i == 0) first_err = last_err;
        end
        end_err = last_err;
    endtask

    function automatic logic [0:NM-1] make_msg(input int kind);
        logic [0:NM-1] m;
        for (int i = 0; i < NM; i++) begin
            case (kind)
                0: m[i] = 1'b0;
                1: m[i] = 1'b1;
                2: m[i] = (i == 0);
                default: begin lcg = lcg * 32'd1664525 + 32'd1013904223; m[i] = lcg[20]; end
            endcase
        end
        return m;
    endfunction

    task automatic test_good(input int kind, input int stall, input string tag);
        logic [0:NM-1] m;
        logic fe, ee;
        m = make_msg(kind);
        send_msg(m, fe, ee);
        check(!ee, {tag, " R7 no error on full message"}, ee, 0);
        collect_check(m, stall, tag);
    endtask

    task automatic test_short(input int len, input string tag);
        for (int i = 0; i < len; i++) push(i[0], i == 0, i == len - 1);
        check(last_err === 1'b1, {tag, " R7 short message flagged"}, last_err, 1);
        expect_idle(20, {tag, " R7 short message dropped"});
    endtask

    task automatic test_long;
        logic [0:NM-1] m;
        logic fe, ee;
        for (int i = 0; i <= NM; i++) push(1'b1, i == 0, 1'b0);
        check(last_err === 1'b1, "R8 overrun flagged", last_err, 1);
        for (int i = 0; i < 5; i++) push(1'b0, 1'b0, i == 4);
        check(last_err === 1'b0, "R8 trailing bits ignored", last_err, 0);
        expect_idle(20, "R8 overrun dropped");
        m = make_msg(3);
        send_msg(m, fe, ee);
        collect_check(m, 0, "R8 recovery");
    endtask

    task automatic test_stray;
        logic [0:NM-1] m;
        logic fe, ee;
        int errs = 0;
        for (int i = 0; i < 12; i++) begin
            push(1'b1, 1'b0, i == 11);
            if (last_err) errs++;
        end
        check(errs == 0, "R9 stray bits raise nothing", errs, 0);
        expect_idle(20, "R9 stray bits emit nothing");
        m = make_msg(3);
        send_msg(m, fe, ee);
        collect_check(m, 0, "R9 after stray");
    endtask

    task automatic test_restart;
        logic [0:NM-1] m;
        logic fe, ee;
        for (int i = 0; i < 50; i++) push(1'b1, i == 0, 1'b0);
        m = make_msg(3);
        send_msg(m, fe, ee);
        check(fe === 1'b1, "R10 restart flags old message", fe, 1);
        check(ee === 1'b0, "R10 new message accepted", ee, 0);
        collect_check(m, 1, "R10 new message");
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(!out_valid && in_ready && !len_err, "R11 reset state",
              {out_valid, in_ready, len_err}, 3'b010);
        rst = 1'b0;
        test_good(0, 0, "zeros");
        test_good(1, 0, "ones");
        test_good(2, 1, "single");
        test_good(3, 1, "mixed");
        test_short(100, "len100");
        test_short(NM - 1, "len183");
        test_short(1, "len1");
        test_long();
        test_stray();
        test_restart();
        finish_run();
    end
endmodule